// File: doc/BRIEF.md
# Command-Driven MDIO Management Engine

This engine sits in the register space of a switch. It lets host software reach the registers of the internal PHYs without driving the management pins itself. Software writes a 16-bit command word that packs the framing style, opcode, PHY address and register number. Setting the top bit of that word starts the transfer. The engine then serialises a complete management frame on an MDC/MDIO master port. The same top bit reads back as busy until the last data bit has passed.

Write data goes through a separate 16-bit data register. For a write, software loads the data register and then writes the command. For a read, the engine puts the value sampled from the PHY into the data register at the moment busy drops. Software polls busy before it issues the next command.

The frame sequencer walks five named states:

- IDLE to PREAMBLE when a command with the busy bit set is accepted.
- PREAMBLE to HEADER after 32 bit periods.
- HEADER to TURN after 14 bits (start code, opcode, PHY address, register field).
- TURN to DATA after 2 bits.
- DATA back to IDLE after 16 bits. This last transition is the completion.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command and data registers read 0x0000, MDC is low and the MDIO output enable is 0.
- R2: The command register is decoded at register offset 0x18 and reads back {busy, stored bits 14:0}. The data register at offset 0x19 reads back its 16-bit contents. Any other offset reads 0x0000.
- R3: Writing the command register with bit 15 set while idle starts a frame. Bit 15 reads 1 from the next cycle for exactly 64 MDC periods (64 x 2 x HALF_DIV system cycles), then reads 0.
- R4: A write frame drives these bits, MSB first throughout:
  - 32 ones;
  - the start code (01 when command bit 12 is set);
  - the opcode from command bits 11:10 (01 means write);
  - the PHY address from bits 9:5;
  - the register number from bits 4:0;
  - the turnaround pattern 10;
  - the 16 bits that the data register held when the command was accepted.
- R5: During a read (opcode bit 11 set), the output enable is 1 for the first 46 bits and 0 for the 2 turnaround and 16 data bits. MDIO is sampled on each rising MDC edge of the data bits, and the 16-bit result is in the data register when busy clears.
- R6: While busy, writes to the command register and to the data register are ignored. This includes a write landing on the completion cycle. A read result captured in that cycle wins.
- R7: With command bit 12 clear, the frame uses start code 00, sends opcode bits 11:10 unchanged, and places bits 4:0 (the device address) in the register field. Opcodes 00 and 01 drive the data register; opcodes 10 and 11 read.
- R8: A command write with bit 15 clear stores bits 14:0 but starts no frame and produces no MDC edge.
- R9: MDC has a period of 2 x HALF_DIV system cycles while a frame runs and stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_in | input | 1 | MDIO value seen on the pad |

## Verification
Two events can fall in the same cycle: the completion of a frame, which loads a read result and drops busy, and a host register write. The bench provokes this by timing a data-register write, and separately a command write, to land exactly on the 256th cycle after a command is accepted. The expected result is that the captured PHY value survives in the data register. The late command must neither start a frame nor change the command readback.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int DAT_BITS = 16;
    localparam int BCNT_W   = $clog2(PRE_BITS);
    localparam int GO_BIT   = 15;
    localparam int C22_BIT  = 12;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PREAMBLE,
        FS_HEADER,
        FS_TURN,
        FS_DATA
    } fstate_e;

    typedef struct packed {
        logic       c22;
        logic [1:0] op;
        logic [4:0] phy;
        logic [4:0] reg_sel;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic bit_end
);
    localparam int PER = 2 * HALF_DIV;
    localparam int CW  = $clog2(PER);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        rise    = run && (cnt_q == CW'(HALF_DIV - 1));
        bit_end = run && (cnt_q == CW'(PER - 1));
        if (!run || bit_end) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            mdc   <= run && (cnt_d >= CW'(HALF_DIV));
        end
    end

    // R9
    mdc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $past(run));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  mdio_cmd_t           cmd,
    input  logic [DAT_BITS-1:0] wdata,
    input  logic                rise,
    input  logic                bit_end,
    input  logic                mdio_in,
    output logic                busy,
    output logic                done,
    output logic [DAT_BITS-1:0] rd_data,
    output logic                mdio_out,
    output logic                mdio_oe
);
    fstate_e             state_q, state_d;
    logic [BCNT_W-1:0]   idx_q;
    logic                last;
    logic                rd_q;
    logic [HDR_BITS-1:0] hdr_sh;
    logic [DAT_BITS-1:0] dat_sh;
    logic [DAT_BITS-1:0] cap_sh;

    always_comb begin
        unique case (state_q)
            FS_PREAMBLE: last = (idx_q == BCNT_W'(PRE_BITS - 1));
            FS_HEADER:   last = (idx_q == BCNT_W'(HDR_BITS - 1));
            FS_TURN:     last = (idx_q == BCNT_W'(TA_BITS - 1));
            FS_DATA:     last = (idx_q == BCNT_W'(DAT_BITS - 1));
            default:     last = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:     if (start)            state_d = FS_PREAMBLE;
            FS_PREAMBLE: if (bit_end && last)  state_d = FS_HEADER;
            FS_HEADER:   if (bit_end && last)  state_d = FS_TURN;
            FS_TURN:     if (bit_end && last)  state_d = FS_DATA;
            FS_DATA:     if (bit_end && last)  state_d = FS_IDLE;
            default:                           state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mdio_oe  = 1'b0;
        mdio_out = 1'b1;
        busy     = (state_q != FS_IDLE);
        done     = (state_q == FS_DATA) && bit_end && last;
        rd_data  = cap_sh;
        unique case (state_q)
            FS_IDLE:     mdio_oe = 1'b0;
            FS_PREAMBLE: mdio_oe = 1'b1;
            FS_HEADER: begin
                mdio_oe  = 1'b1;
                mdio_out = hdr_sh[HDR_BITS-1];
            end
            FS_TURN: begin
                mdio_oe  = !rd_q;
                mdio_out = (idx_q == '0);
            end
            FS_DATA: begin
                mdio_oe  = !rd_q;
                mdio_out = dat_sh[DAT_BITS-1];
            end
            default: mdio_oe = 1'b0;
        endcase
    end

    // datapath: snapshot at start, shift per bit, capture on rising MDC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rd_q   <= 1'b0;
            hdr_sh <= '0;
            dat_sh <= '0;
            cap_sh <= '0;
        end else begin
            if (start && state_q == FS_IDLE) begin
                idx_q  <= '0;
                rd_q   <= cmd.op[1];
                hdr_sh <= {1'b0, cmd.c22, cmd.op, cmd.phy, cmd.reg_sel};
                dat_sh <= wdata;
            end else if (bit_end) begin
                idx_q <= last ? '0 : idx_q + 1'b1;
                if (state_q == FS_HEADER) hdr_sh <= {hdr_sh[HDR_BITS-2:0], 1'b0};
                if (state_q == FS_DATA)   dat_sh <= {dat_sh[DAT_BITS-2:0], 1'b0};
            end
            if (rise && state_q == FS_DATA && rd_q)
                cap_sh <= {cap_sh[DAT_BITS-2:0], mdio_in};
        end
    end

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state_q == FS_DATA && rd_q) |-> !mdio_oe);
    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int             HALF_DIV = 2,
    parameter int             AW       = 5,
    parameter logic [AW-1:0]  CMD_OFS  = AW'(5'h18),
    parameter logic [AW-1:0]  DATA_OFS = AW'(5'h19)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic                mdc,
    output logic                mdio_out,
    output logic                mdio_oe,
    input  logic                mdio_in
);
    logic [GO_BIT-1:0]   cmd_q;
    logic [DAT_BITS-1:0] data_q;
    logic                busy, done, rise, bit_end;
    logic [DAT_BITS-1:0] rd_data;
    logic                cmd_acc, data_acc, start;
    mdio_cmd_t           new_cmd;

    always_comb begin
        cmd_acc  = reg_we && (reg_addr == CMD_OFS)  && !busy;
        data_acc = reg_we && (reg_addr == DATA_OFS) && !busy;
        start    = cmd_acc && reg_wdata[GO_BIT];
        new_cmd  = '{c22: reg_wdata[C22_BIT], op: reg_wdata[11:10],
                     phy: reg_wdata[9:5], reg_sel: reg_wdata[4:0]};
        if (reg_addr == CMD_OFS)       reg_rdata = {busy, cmd_q};
        else if (reg_addr == DATA_OFS) reg_rdata = data_q;
        else                           reg_rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (cmd_acc)  cmd_q <= reg_wdata[GO_BIT-1:0];
            if (data_acc) data_q <= reg_wdata;
            else if (done && cmd_q[11]) data_q <= rd_data;
        end
    end

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise(rise), .bit_end(bit_end)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(new_cmd),
        .wdata(data_q), .rise(rise), .bit_end(bit_end), .mdio_in(mdio_in),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_q));
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_q));
    // R9
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R1
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_cmd_engine_bench.sv
`timescale 1ns/1ps
module mdio_cmd_engine_bench;
    localparam int HALF_DIV = 2;
    localparam logic [4:0] CMD = 5'h18;
    localparam logic [4:0] DAT = 5'h19;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    mdio_cmd_engine #(.HALF_DIV(HALF_DIV)) u_mdio_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    typedef struct packed { logic [63:0] bits; logic [63:0] oe; } frame_t;

    int      n_chk = 0, n_err = 0;
    longint  cyc = 0;
    frame_t  exp_q[$];
    frame_t  got, exp_f;
    logic [15:0] phy_val = '0;
    logic    phy_rd = 1'b0;
    int      rise_cnt = 0, bidx = 0, last_period = 0;
    longint  last_rise = 0;
    logic    mdc_prev = 1'b0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // monitor: PHY model plus scoreboard compare
    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            rise_cnt++;
            last_period = int'(cyc - last_rise);
            last_rise = cyc;
            got.bits[63-bidx] = mdio_out;
            got.oe[63-bidx]   = mdio_oe;
            bidx++;
            if (bidx == 64) begin
                bidx = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected frame", got.bits, '0);
                end else begin
                    exp_f = exp_q.pop_front();
                    check(got.oe == exp_f.oe, "R5", "output-enable pattern", got.oe, exp_f.oe);
                    check(((got.bits ^ exp_f.bits) & exp_f.oe) == '0, "R4", "frame bits",
                          got.bits & exp_f.oe, exp_f.bits & exp_f.oe);
                end
            end
            mdio_in = (phy_rd && bidx >= 48) ? phy_val[63-bidx] : 1'b1;
        end
        mdc_prev = mdc;
    end

    function automatic frame_t mk_frame(input bit c22, input logic [1:0] op,
                                        input logic [4:0] pa, input logic [4:0] ra,
                                        input logic [15:0] wd);
        frame_t f;
        f.bits = {32'hFFFF_FFFF, 1'b0, c22, op, pa, ra,
                  op[1] ? 2'b00 : 2'b10, op[1] ? 16'h0000 : wd};
        f.oe   = op[1] ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
        return f;
    endfunction

    task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_read(CMD, v);
            if (!v[15]) break;
        end
    endtask

    // driver: push expected frame, then issue command
    task automatic do_cmd(input bit c22, input logic [1:0] op, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd,
                          input logic [15:0] rv);
        exp_q.push_back(mk_frame(c22, op, pa, ra, wd));
        phy_rd  = op[1];
        phy_val = rv;
        if (!op[1]) reg_write(DAT, wd);
        reg_write(CMD, {1'b1, 2'b00, c22, op, pa, ra});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        logic [15:0] v;
        int          rc;
        repeat (4) @(posedge clk);
        @(negedge clk);

        // R1 reset state (still in reset)
        reg_read(CMD, v); check(v == 16'h0, "R1", "cmd after reset", v, 16'h0);
        reg_read(DAT, v); check(v == 16'h0, "R1", "data after reset", v, 16'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset", {mdc, mdio_oe}, 2'b00);
        rst_n = 1'b1;

        // R2 decode
        reg_write(DAT, 16'hA5C3);
        @(negedge clk);
        reg_read(DAT, v);   check(v == 16'hA5C3, "R2", "data readback", v, 16'hA5C3);
        reg_read(5'h00, v); check(v == 16'h0, "R2", "offset 0x00", v, 16'h0);
        reg_read(5'h1A, v); check(v == 16'h0, "R2", "offset 0x1A", v, 16'h0);

        // R3/R4 clause 22 write with busy timing
        do_cmd(1'b1, 2'b01, 5'h03, 5'h11, 16'hBEEF, 16'h0);
        @(negedge clk);
        reg_read(CMD, v); check(v[15] == 1'b1, "R3", "busy right after start", v[15], 1'b1);
        repeat (255) @(negedge clk);
        reg_read(CMD, v); check(v[15] == 1'b1, "R3", "busy in last cycle", v[15], 1'b1);
        @(negedge clk);
        reg_read(CMD, v); check(v[15] == 1'b0, "R3", "busy cleared on time", v[15], 1'b0);
        check(v == 16'h1471, "R2", "cmd readback", v, 16'h1471);
        reg_read(DAT, v); check(v == 16'hBEEF, "R4", "write leaves data reg", v, 16'hBEEF);

        // R9 MDC
        check(last_period == 2 * HALF_DIV, "R9", "mdc period", last_period, 2 * HALF_DIV);
        repeat (8) @(negedge clk);
        check(mdc == 1'b0, "R9", "mdc low when idle", mdc, 1'b0);

        // R5 clause 22 read
        do_cmd(1'b1, 2'b10, 5'h1F, 5'h00, 16'h0, 16'h5A3C);
        wait_idle();
        reg_read(DAT, v); check(v == 16'h5A3C, "R5", "read result", v, 16'h5A3C);

        // R6 writes while busy mid-frame
        do_cmd(1'b1, 2'b10, 5'h02, 5'h05, 16'h0, 16'hC0DE);
        repeat (100) @(negedge clk);
        reg_write(CMD, {1'b1, 2'b00, 1'b1, 2'b01, 5'h1A, 5'h1B});
        reg_write(DAT, 16'h1111);
        @(negedge clk);
        reg_read(CMD, v); check(v == 16'h9845, "R6", "cmd kept while busy", v, 16'h9845);
        wait_idle();
        reg_read(DAT, v); check(v == 16'hC0DE, "R6", "data write ignored while busy", v, 16'hC0DE);

        // R6 data write on the completion cycle of a read
        do_cmd(1'b1, 2'b10, 5'h06, 5'h0C, 16'h0, 16'h0F0F);
        repeat (255) @(negedge clk);
        reg_write(DAT, 16'hFFFF);
        @(negedge clk);
        reg_read(DAT, v); check(v == 16'h0F0F, "R6", "capture wins over same-cycle write", v, 16'h0F0F);

        // R6 command write on the completion cycle of a write
        do_cmd(1'b1, 2'b01, 5'h09, 5'h02, 16'h1234, 16'h0);
        repeat (255) @(negedge clk);
        reg_write(CMD, {1'b1, 2'b00, 1'b1, 2'b10, 5'h15, 5'h15});
        rc = rise_cnt;
        repeat (40) @(negedge clk);
        reg_read(CMD, v); check(v == 16'h1522, "R6", "late cmd not taken", v, 16'h1522);
        check(rise_cnt == rc, "R6", "no frame from late cmd", rise_cnt, rc);

        // R8 command without go bit
        reg_write(CMD, {1'b0, 2'b00, 1'b1, 2'b10, 5'd7, 5'd9});
        rc = rise_cnt;
        repeat (40) @(negedge clk);
        reg_read(CMD, v); check(v == 16'h18E9, "R8", "fields stored, not busy", v, 16'h18E9);
        check(rise_cnt == rc, "R8", "no mdc edge", rise_cnt, rc);

        // R7 clause 45 address write, data write, read
        do_cmd(1'b0, 2'b00, 5'h04, 5'h01, 16'h0ABC, 16'h0);
        wait_idle();
        do_cmd(1'b0, 2'b01, 5'h04, 5'h01, 16'h3C5A, 16'h0);
        wait_idle();
        do_cmd(1'b0, 2'b10, 5'h04, 5'h01, 16'h0, 16'h7E81);
        wait_idle();
        reg_read(DAT, v); check(v == 16'h7E81, "R7", "clause 45 read result", v, 16'h7E81);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4", "all frames seen", exp_q.size(), 0);
        report();
    end
endmodule